// File: doc/BRIEF.md
# Clocked Burst Read Sequencer

This block produces the clocked read stream of a NOR flash. In a cycle where the chip is selected and the address-valid strobe is low, it captures a start address, a latency setting, a burst-length code and an array/non-array flag. It then waits a programmable number of clock edges and delivers one 16-bit word per clock edge until the burst is complete.

The storage itself sits outside the block. The sequencer drives a word address on `mem_addr` and registers the word that comes back on `mem_rdata` into `dq`. Array bursts step through a linear sequence that wraps inside an aligned window of the burst length. Non-array bursts (identifier, status or query data) keep presenting the word at the start address. When the read configuration selects asynchronous page mode, the sequencer stays idle.

`data_wait` is high while data is not yet valid. Raising the chip select at any edge abandons the burst.

Top module: `burst_read_seq`

## Requirements
- R1: While `rst_n` is low, and after its release, `dq_valid` and `data_wait` are 0 and `dq` is 0.
- R2: A clock edge with `ce_n`=0, `adv_n`=0 and `cfg_async`=0 in the idle state captures `addr`, `lat_cfg`, `len_cfg` and `array_rd`. `data_wait` is 1 and `dq_valid` is 0 in the following cycle.
- R3: While `cfg_async`=1, no burst starts. `data_wait` and `dq_valid` stay 0 whatever `ce_n` and `adv_n` do.
- R4: With latency L = `lat_cfg`, where the codes 0 and 1 act as 2, the first word is valid after the L-th clock edge following the capture edge. `data_wait` stays 1 until then and is 0 while `dq_valid` is 1.
- R5: `len_cfg` codes 0, 1 and 2 give bursts of N = 4, 8 and 16 words. After the first word a new word is presented after every edge, for N words. `dq_valid` and `data_wait` are then both 0.
- R6: In an array burst (`array_rd`=1) with codes 0 to 2, word k comes from the start address with its low log2(N) bits replaced by (start + k) mod N. The upper bits are unchanged.
- R7: `len_cfg` code 3 is a continuous burst. Word k comes from address start + k (modulo 2^AW) for an array read, and the burst ends only when `ce_n` rises.
- R8: In a non-array burst (`array_rd`=0), every word of the burst is the word at the start address.
- R9: If `ce_n` is 1 at any clock edge, the next cycle shows `dq_valid`=0 and `data_wait`=0, and a new burst can then be started.
- R10: Changes to `addr`, `lat_cfg`, `len_cfg`, `array_rd` and `adv_n` after the capture edge do not affect the burst in progress.
- R11: After a burst of finite length ends, no new burst starts while `adv_n` stays low. `adv_n` or `ce_n` must first be sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select; high aborts any burst |
| adv_n | input | 1 | Active-low address-valid strobe |
| cfg_async | input | 1 | 1 selects asynchronous page mode (sequencer inert) |
| addr | input | AW (16) | Start word address |
| lat_cfg | input | LAT_W (3) | Initial latency in clocks, 2 to 7 (0 and 1 act as 2) |
| len_cfg | input | 2 | Burst length: 0=4, 1=8, 2=16, 3=continuous |
| array_rd | input | 1 | 1 = array read (address steps), 0 = non-array (word repeats) |
| mem_addr | output | AW (16) | Word address presented to storage |
| mem_rdata | input | DW (16) | Word returned by storage for `mem_addr`, same cycle |
| dq | output | DW (16) | Output data word |
| dq_valid | output | 1 | `dq` holds a valid burst word |
| data_wait | output | 1 | Data not yet valid after address capture |

## Verification
The bench builds the block with its default 16-bit address and data and a 3-bit latency field. This makes every latency code from 0 to 7 and every burst-length code reachable, and the bench sweeps all of them for both array and non-array reads. It uses start addresses that sit near a wrap boundary and at the top of the address space, so the in-window wrap and the unbounded continuous increment can both be seen in the data. Storage is modelled as an arithmetic function of the address, so each expected word follows from the expected address sequence.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LAT   = 2'd1,
    ST_BURST = 2'd2,
    ST_END   = 2'd3
  } bseq_state_e;

  localparam int LEN_W = 2;
  localparam logic [LEN_W-1:0] LEN_CONT = 2'd3;
endpackage

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import bseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]    start_addr,
  input  logic [AW-1:0]    beat_idx,
  input  logic [LEN_W-1:0] len_code,
  input  logic             is_array,
  output logic [AW-1:0]    rd_addr
);
  localparam logic [AW-1:0] MIN_BEATS = AW'(4);

  logic [AW-1:0] win_mask;
  logic [AW-1:0] lin_sum;

  always_comb begin
    win_mask = (MIN_BEATS << len_code) - AW'(1);
    lin_sum  = start_addr + beat_idx;
    if (!is_array)
      rd_addr = start_addr;
    else if (len_code == LEN_CONT)
      rd_addr = lin_sum;
    else
      rd_addr = (start_addr & ~win_mask) | (lin_sum & win_mask);
  end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             cfg_async,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic             array_rd,
  output logic             capture,
  output logic             load_word,
  output logic [AW-1:0]    beat_idx,
  output logic [LEN_W-1:0] len_q,
  output logic             arr_q,
  output logic             in_latency,
  output logic             in_burst
);
  localparam logic [LAT_W-1:0] LAT_MIN   = LAT_W'(2);
  localparam logic [AW-1:0]    MIN_BEATS = AW'(4);

  bseq_state_e      st_q, st_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [LAT_W-1:0] lat_q, lat_eff;
  logic [AW-1:0]    idx_q, idx_d;
  logic [AW-1:0]    n_beats;
  logic             start_ok;

  assign start_ok = !ce_n && !adv_n && !cfg_async;
  assign lat_eff  = (lat_cfg < LAT_MIN) ? LAT_MIN : lat_cfg;
  assign n_beats  = MIN_BEATS << len_q;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    capture   = 1'b0;
    load_word = 1'b0;
    if (ce_n) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_ok) begin
          capture = 1'b1;
          st_d    = ST_LAT;
          cnt_d   = LAT_W'(1);
          idx_d   = '0;
        end
        ST_LAT: if (cnt_q == lat_q) begin
          load_word = 1'b1;
          idx_d     = idx_q + AW'(1);
          st_d      = ST_BURST;
        end else begin
          cnt_d = cnt_q + LAT_W'(1);
        end
        ST_BURST: if (len_q != LEN_CONT && idx_q == n_beats) begin
          st_d = ST_END;
        end else begin
          load_word = 1'b1;
          idx_d     = idx_q + AW'(1);
        end
        ST_END: if (adv_n) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= LAT_MIN;
      len_q <= '0;
      arr_q <= 1'b0;
    end else if (capture) begin
      lat_q <= lat_eff;
      len_q <= len_cfg;
      arr_q <= array_rd;
    end
  end

  assign beat_idx   = idx_q;
  assign in_latency = (st_q == ST_LAT);
  assign in_burst   = (st_q == ST_BURST);

  AST_CAPTURE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_ok) |=> (in_latency && !in_burst)); // R2

  AST_ASYNC_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_async && st_q == ST_IDLE) |=> (st_q == ST_IDLE)); // R3

  AST_END_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_END && !adv_n && !ce_n) |=> (st_q == ST_END)); // R11
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bseq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             cfg_async,
  input  logic [AW-1:0]    addr,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic [1:0]       len_cfg,
  input  logic             array_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    dq,
  output logic             dq_valid,
  output logic             data_wait
);
  logic             capture;
  logic             load_word;
  logic [AW-1:0]    beat_idx;
  logic [LEN_W-1:0] len_q;
  logic             arr_q;
  logic [AW-1:0]    start_q;
  logic [DW-1:0]    dq_q;

  bseq_ctrl #(.AW(AW), .LAT_W(LAT_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .adv_n      (adv_n),
    .cfg_async  (cfg_async),
    .lat_cfg    (lat_cfg),
    .len_cfg    (len_cfg),
    .array_rd   (array_rd),
    .capture    (capture),
    .load_word  (load_word),
    .beat_idx   (beat_idx),
    .len_q      (len_q),
    .arr_q      (arr_q),
    .in_latency (data_wait),
    .in_burst   (dq_valid)
  );

  bseq_addr_gen #(.AW(AW)) i_addr_gen (
    .start_addr (start_q),
    .beat_idx   (beat_idx),
    .len_code   (len_q),
    .is_array   (arr_q),
    .rd_addr    (mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_q <= '0;
    else if (capture) start_q <= addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dq_q <= '0;
    else if (load_word) dq_q <= mem_rdata;
  end

  assign dq = dq_q;

  // checker counters: latency edges and delivered beats
  logic [3:0] wait_edges;
  logic [7:0] beat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_edges <= '0;
      beat_cnt   <= '0;
    end else begin
      wait_edges <= data_wait ? ((wait_edges == 4'hF) ? wait_edges : wait_edges + 4'd1) : 4'd0;
      beat_cnt   <= dq_valid  ? ((beat_cnt == 8'hFF) ? beat_cnt : beat_cnt + 8'd1) : 8'd0;
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dq_valid && !data_wait)); // R9

  AST_FIRST_WORD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> (wait_edges == 4'(i_ctrl.lat_q))); // R4

  AST_BURST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dq_valid) && !$past(ce_n) && len_q != LEN_CONT)
      |-> (beat_cnt == (8'd4 << len_q))); // R5

  AST_NONARRAY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && $past(dq_valid) && !arr_q) |-> $stable(mem_addr)); // R8

  AST_NO_WAIT_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $fell(data_wait)); // R4
endmodule

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, adv_n, cfg_async;
  logic [15:0] addr;
  logic [2:0]  lat_cfg;
  logic [1:0]  len_cfg;
  logic        array_rd;
  logic [15:0] mem_addr, mem_rdata, dq;
  logic        dq_valid, data_wait;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    return (a * 16'd37) ^ 16'h5A1D;
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  burst_read_seq i_burst_read_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .cfg_async(cfg_async),
    .addr(addr), .lat_cfg(lat_cfg), .len_cfg(len_cfg), .array_rd(array_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dq(dq),
    .dq_valid(dq_valid), .data_wait(data_wait)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] st, input int len,
                                           input bit arr, input int k);
    logic [15:0] m;
    if (!arr) return st;
    if (len == 3) return st + 16'(k);
    m = 16'((4 << len) - 1);
    return (st & ~m) | ((st + 16'(k)) & m);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_burst(input logic [15:0] st, input int lat, input int len,
                           input bit arr, input bit hold_adv, input int cont_words);
    int eff_l = (lat < 2) ? 2 : lat;
    int n = (len == 3) ? cont_words : (4 << len);
    ce_n = 1'b0; adv_n = 1'b0; addr = st;
    lat_cfg = 3'(lat); len_cfg = 2'(len); array_rd = arr;
    step();
    check("R2 wait after capture", 32'(data_wait), 32'd1);
    check("R2 no data at capture", 32'(dq_valid), 32'd0);
    // R10: scramble everything after the capture edge
    addr = ~st; lat_cfg = 3'(lat) ^ 3'd5; len_cfg = ~2'(len); array_rd = ~arr;
    adv_n = !hold_adv;
    for (int e = 1; e < eff_l; e++) begin
      step();
      check("R4 wait during latency", 32'(data_wait), 32'd1);
      check("R4 no early data", 32'(dq_valid), 32'd0);
    end
    for (int k = 0; k < n; k++) begin
      step();
      check("R5 valid per edge", 32'(dq_valid), 32'd1);
      check("R4 wait low with data", 32'(data_wait), 32'd0);
      if (!arr)          check("R8 repeated word", 32'(dq), 32'(mem_fn(st)));
      else if (len == 3) check("R7 continuous word", 32'(dq), 32'(mem_fn(exp_addr(st, len, arr, k))));
      else               check("R6 wrapped word", 32'(dq), 32'(mem_fn(exp_addr(st, len, arr, k))));
    end
    if (len != 3) begin
      step();
      check("R5 burst ended valid", 32'(dq_valid), 32'd0);
      check("R5 burst ended wait", 32'(data_wait), 32'd0);
      if (hold_adv) begin
        addr = st + 16'd3;
        for (int j = 0; j < 3; j++) begin
          step();
          check("R11 no restart wait", 32'(data_wait), 32'd0);
          check("R11 no restart data", 32'(dq_valid), 32'd0);
        end
      end
    end
    ce_n = 1'b1; adv_n = 1'b1;
    step();
    check("R9 idle after ce high valid", 32'(dq_valid), 32'd0);
    check("R9 idle after ce high wait", 32'(data_wait), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] starts [3];
    starts[0] = 16'h00FD; starts[1] = 16'h1230; starts[2] = 16'hFFFE;
    rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; cfg_async = 1'b0;
    addr = '0; lat_cfg = 3'd2; len_cfg = 2'd0; array_rd = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(dq_valid), 32'd0);
    check("R1 reset wait", 32'(data_wait), 32'd0);
    check("R1 reset dq", 32'(dq), 32'd0);
    rst_n = 1'b1;
    step();
    check("R1 after release valid", 32'(dq_valid), 32'd0);
    check("R1 after release wait", 32'(data_wait), 32'd0);

    // R3: asynchronous page mode selected, strobes ignored
    cfg_async = 1'b1; ce_n = 1'b0; adv_n = 1'b0; addr = 16'h0040;
    for (int j = 0; j < 10; j++) begin
      step();
      check("R3 async mode wait", 32'(data_wait), 32'd0);
      check("R3 async mode data", 32'(dq_valid), 32'd0);
    end
    ce_n = 1'b1; adv_n = 1'b1; cfg_async = 1'b0;
    step();

    // full sweep: latency codes, length codes, array flag, start addresses
    for (int lat = 0; lat < 8; lat++)
      for (int len = 0; len < 4; len++)
        for (int arr = 0; arr < 2; arr++)
          for (int s = 0; s < 3; s++)
            run_burst(starts[s], lat, len, arr[0], bit'((lat + s) % 2), 20);

    // R9: abort in the middle of the latency window, then restart
    ce_n = 1'b0; adv_n = 1'b0; addr = 16'h0100; lat_cfg = 3'd7; len_cfg = 2'd0; array_rd = 1'b1;
    step();
    adv_n = 1'b1;
    step(); step();
    ce_n = 1'b1;
    step();
    check("R9 abort in latency wait", 32'(data_wait), 32'd0);
    check("R9 abort in latency data", 32'(dq_valid), 32'd0);
    step();
    run_burst(16'h0107, 3, 1, 1'b1, 1'b0, 20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule